// File: doc/BRIEF.md
# TLB Entry Maintenance Register Port

This block is the software-facing register front end of a translation buffer. Through a single register port (register number, read strobe, write strobe, 32-bit data and an upper-half flag), software selects a buffer entry with an index register. It then reads or writes that entry's tag word and its 64-bit data word, and it maintains the process identifier and the zone protection word that the translation lookup consumes. The entry storage sits outside the block. The block drives the write enables, index and write data for a tag array, a data array and a per-entry owner-tag array, and it reads them back asynchronously.

Tag maintenance moves the process identifier in both directions. Writing a tag stamps the current identifier into that entry's owner tag. Reading a tag loads the entry's owner tag back into the identifier register. A search register takes a virtual address and starts a read-type lookup in the external translation unit. The block then either moves the matching entry number into the index register or raises a sticky miss flag in it. A fixed access level, set as a parameter, decides which registers may be read or written.

Top module: `tlbMaintRegs`

## Requirements
- R1: After reset the identifier, zone and index registers read zero and busy is low.
- R2: A write to the index register (number 4) stores bits 30:0. Bit 31 is the miss flag and is never changed by such a write. The low log2(ENTRIES) bits of the index drive the entry index.
- R3: A write to the tag register (number 1) stores the value in the tag array at the current index. In the same cycle it stores the low 8 bits of the identifier register as that entry's owner tag.
- R4: A write to the data register (number 0) stores the value in bits 31:0 of the indexed data word, or in bits 63:32 when the upper-half flag is set.
- R5: A read of the tag register returns the indexed tag word. From the next cycle the identifier register holds that entry's owner tag.
- R6: A read of the data register returns bits 31:0 of the indexed data word, or bits 63:32 when the upper-half flag is set.
- R7: A write to the search register (number 5) raises busy and the lookup request for exactly one cycle. The request carries the written address with bits below VPN_LSB cleared, and the current user-mode flag. On a hit the index becomes the matched entry number, with all other bits zero. On a miss bit 31 is set and the other bits are kept.
- R8: The search register reads 0. Register numbers 6 and 7 ignore writes and read 0.
- R9: An upper-half access to any register other than the data register is ignored, and such a read returns 0.
- R10: Identifier, zone and search writes take effect only when the access level is above 1.
- R11: Tag, data, identifier and zone reads return data only when bit 0 of the access level is set; otherwise they return 0 and a tag read leaves the identifier unchanged. The index register stays readable at any nonzero level, and level 0 ignores every access.
- R12: While busy is high, every register access is ignored and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regExt | input | 1 | Upper-half access flag |
| regNum | input | 3 | Register number |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the cycle of regRd |
| userMode | input | 1 | Current privilege mode, 1 = user |
| busy | output | 1 | Search in progress |
| ramIdx | output | log2(ENTRIES) | Entry index to the arrays |
| tagWe | output | 1 | Tag array write enable |
| dataWeLo | output | 1 | Data array lower-half write enable |
| dataWeHi | output | 1 | Data array upper-half write enable |
| ramWdata | output | 32 | Array write data |
| tidWe | output | 1 | Owner-tag array write enable |
| tidWdata | output | 8 | Owner tag to store |
| tagRdata | input | 32 | Tag word at ramIdx |
| dataRdata | input | 64 | Data word at ramIdx |
| tidRdata | input | 8 | Owner tag at ramIdx |
| srchReq | output | 1 | Lookup request |
| srchVpn | output | 32 | Lookup address, page bits only |
| srchUser | output | 1 | Lookup mode, 1 = user |
| srchHit | input | 1 | Lookup hit, sampled while srchReq is high |
| srchIdx | input | log2(ENTRIES) | Matched entry number |
| curPid | output | 8 | Current process identifier |
| zoneProt | output | 32 | Zone protection word |

## Verification
The bench builds three copies with 64 entries and a 10-bit page offset, at access levels 3, 2 and 1. The level-3 copy carries the full data path against a behavioural model of the three arrays: owner-tag stamping and reload, both data halves, hit and miss searches, the miss flag's survival across index writes, and accesses dropped during busy. The level-2 copy shows identifier writes taking effect while identifier and tag reads return zero without reloading the identifier. The level-1 copy shows identifier, zone and search writes being refused while reads still work.

// File: rtl/tlbRegPkg.sv
package tlbRegPkg;

  typedef enum logic [2:0] {
    REG_DATA   = 3'd0,
    REG_TAG    = 3'd1,
    REG_PID    = 3'd2,
    REG_ZONE   = 3'd3,
    REG_INDEX  = 3'd4,
    REG_SEARCH = 3'd5
  } regSelE;

  typedef struct packed {
    logic   dataLoWr;
    logic   dataHiWr;
    logic   tagWr;
    logic   pidWr;
    logic   zoneWr;
    logic   idxWr;
    logic   tagRd;
    logic   srchStart;
    logic   srchCommit;
    logic   rdValid;
    logic   rdHi;
    regSelE rdSel;
  } strobeT;

endpackage

// File: rtl/tlbRegCtl.sv
module tlbRegCtl
  import tlbRegPkg::*;
#(
  parameter int unsigned ACCESS_LEVEL = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic       regRd,
  input  logic       regExt,
  input  logic [2:0] regNum,
  output logic       busy,
  output strobeT     strb
);

  localparam logic [1:0] LVL      = ACCESS_LEVEL[1:0];
  localparam bit         ANY_OK   = (LVL != 2'd0);
  localparam bit         READ_OK  = LVL[0];
  localparam bit         CTRL_OK  = (LVL > 2'd1);

  logic accept;
  logic extOk;
  logic wrOk;
  logic rdOk;

  assign accept = ANY_OK && !busy;
  assign extOk  = !regExt || (regNum == REG_DATA);
  assign wrOk   = regWr && accept && extOk;
  assign rdOk   = regRd && accept && extOk;

  always_comb begin
    strb            = '0;
    strb.rdSel      = regSelE'(regNum);
    strb.rdHi       = regExt;
    strb.srchCommit = busy;
    if (wrOk) begin
      case (regNum)
        REG_DATA:   begin
          strb.dataHiWr = regExt;
          strb.dataLoWr = !regExt;
        end
        REG_TAG:    strb.tagWr     = 1'b1;
        REG_PID:    strb.pidWr     = CTRL_OK;
        REG_ZONE:   strb.zoneWr    = CTRL_OK;
        REG_INDEX:  strb.idxWr     = 1'b1;
        REG_SEARCH: strb.srchStart = CTRL_OK;
        default:    ;
      endcase
    end
    if (rdOk) begin
      case (regNum)
        REG_DATA, REG_PID, REG_ZONE: strb.rdValid = READ_OK;
        REG_TAG: begin
          strb.rdValid = READ_OK;
          strb.tagRd   = READ_OK;
        end
        REG_INDEX: strb.rdValid = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busy <= 1'b0;
    else       busy <= strb.srchStart;
  end

  // R7: a search occupies exactly one busy cycle
  a_r7_busy_single: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R7: busy only follows a search-register write
  a_r7_busy_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWr && !regExt && regNum == REG_SEARCH));

endmodule

// File: rtl/tlbRegDp.sv
module tlbRegDp
  import tlbRegPkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned TID_W   = 8,
  parameter int unsigned VPN_LSB = 10,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [31:0]       regWdata,
  input  logic              userMode,
  output logic [31:0]       regRdata,
  output logic [IDX_W-1:0]  ramIdx,
  output logic              tagWe,
  output logic              dataWeLo,
  output logic              dataWeHi,
  output logic [31:0]       ramWdata,
  output logic              tidWe,
  output logic [TID_W-1:0]  tidWdata,
  input  logic [31:0]       tagRdata,
  input  logic [63:0]       dataRdata,
  input  logic [TID_W-1:0]  tidRdata,
  output logic              srchReq,
  output logic [31:0]       srchVpn,
  output logic              srchUser,
  input  logic              srchHit,
  input  logic [IDX_W-1:0]  srchIdx,
  output logic [TID_W-1:0]  curPid,
  output logic [31:0]       zoneProt
);

  localparam logic [31:0] VPN_MASK = ~((32'd1 << VPN_LSB) - 32'd1);

  logic [31:0] pidReg;
  logic [31:0] zoneReg;
  logic [31:0] idxReg;
  logic [31:0] vpnReg;
  logic        userReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pidReg  <= '0;
      zoneReg <= '0;
      idxReg  <= '0;
      vpnReg  <= '0;
      userReg <= 1'b0;
    end else begin
      if (strb.pidWr)      pidReg <= regWdata;
      else if (strb.tagRd) pidReg <= {{(32-TID_W){1'b0}}, tidRdata};
      if (strb.zoneWr) zoneReg <= regWdata;
      if (strb.srchCommit) begin
        if (srchHit) idxReg     <= {{(32-IDX_W){1'b0}}, srchIdx};
        else         idxReg[31] <= 1'b1;
      end else if (strb.idxWr) begin
        idxReg[30:0] <= regWdata[30:0];
      end
      if (strb.srchStart) begin
        vpnReg  <= regWdata & VPN_MASK;
        userReg <= userMode;
      end
    end
  end

  assign ramIdx   = idxReg[IDX_W-1:0];
  assign ramWdata = regWdata;
  assign tagWe    = strb.tagWr;
  assign tidWe    = strb.tagWr;
  assign tidWdata = pidReg[TID_W-1:0];
  assign dataWeLo = strb.dataLoWr;
  assign dataWeHi = strb.dataHiWr;
  assign srchReq  = strb.srchCommit;
  assign srchVpn  = vpnReg;
  assign srchUser = userReg;
  assign curPid   = pidReg[TID_W-1:0];
  assign zoneProt = zoneReg;

  always_comb begin
    regRdata = '0;
    if (strb.rdValid) begin
      case (strb.rdSel)
        REG_DATA:  regRdata = strb.rdHi ? dataRdata[63:32] : dataRdata[31:0];
        REG_TAG:   regRdata = tagRdata;
        REG_PID:   regRdata = pidReg;
        REG_ZONE:  regRdata = zoneReg;
        REG_INDEX: regRdata = idxReg;
        default:   regRdata = '0;
      endcase
    end
  end

  // R7: a hit replaces the whole index with the matched entry
  a_r7_hit_commit: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.srchCommit && srchHit) |-> idxReg == {{(32-IDX_W){1'b0}}, $past(srchIdx)});

  // R7: a miss raises the flag and keeps the rest
  a_r7_miss_flag: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.srchCommit && !srchHit) |-> idxReg[31] && idxReg[30:0] == $past(idxReg[30:0]));

  // R2: software index writes leave the miss flag alone
  a_r2_miss_ro: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.idxWr && !strb.srchCommit) |-> idxReg[31] == $past(idxReg[31]));

  // R10: identifier changes only through its own write or a tag read
  a_r10_pid_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(!strb.pidWr && !strb.tagRd) |-> $stable(pidReg));

  // R10: zone word changes only through an accepted write
  a_r10_zone_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(!strb.zoneWr) |-> $stable(zoneReg));

endmodule

// File: rtl/tlbMaintRegs.sv
module tlbMaintRegs
  import tlbRegPkg::*;
#(
  parameter int unsigned ENTRIES      = 64,
  parameter int unsigned VPN_LSB      = 10,
  parameter int unsigned ACCESS_LEVEL = 3,
  localparam int unsigned IDX_W       = $clog2(ENTRIES),
  localparam int unsigned TID_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              regExt,
  input  logic [2:0]        regNum,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              userMode,
  output logic              busy,
  output logic [IDX_W-1:0]  ramIdx,
  output logic              tagWe,
  output logic              dataWeLo,
  output logic              dataWeHi,
  output logic [31:0]       ramWdata,
  output logic              tidWe,
  output logic [TID_W-1:0]  tidWdata,
  input  logic [31:0]       tagRdata,
  input  logic [63:0]       dataRdata,
  input  logic [TID_W-1:0]  tidRdata,
  output logic              srchReq,
  output logic [31:0]       srchVpn,
  output logic              srchUser,
  input  logic              srchHit,
  input  logic [IDX_W-1:0]  srchIdx,
  output logic [TID_W-1:0]  curPid,
  output logic [31:0]       zoneProt
);

  strobeT strb;

  tlbRegCtl #(.ACCESS_LEVEL(ACCESS_LEVEL)) i_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .regWr  (regWr),
    .regRd  (regRd),
    .regExt (regExt),
    .regNum (regNum),
    .busy   (busy),
    .strb   (strb)
  );

  tlbRegDp #(.ENTRIES(ENTRIES), .TID_W(TID_W), .VPN_LSB(VPN_LSB)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWdata  (regWdata),
    .userMode  (userMode),
    .regRdata  (regRdata),
    .ramIdx    (ramIdx),
    .tagWe     (tagWe),
    .dataWeLo  (dataWeLo),
    .dataWeHi  (dataWeHi),
    .ramWdata  (ramWdata),
    .tidWe     (tidWe),
    .tidWdata  (tidWdata),
    .tagRdata  (tagRdata),
    .dataRdata (dataRdata),
    .tidRdata  (tidRdata),
    .srchReq   (srchReq),
    .srchVpn   (srchVpn),
    .srchUser  (srchUser),
    .srchHit   (srchHit),
    .srchIdx   (srchIdx),
    .curPid    (curPid),
    .zoneProt  (zoneProt)
  );

endmodule

// File: tb/test_tlbMaintRegs.sv
module test_tlbMaintRegs;

  localparam int CLK_PERIOD = 10;
  localparam int ENT = 64;
  localparam int IW  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0]  wrSel = '0, rdSel = '0;
  logic        regExt = 1'b0, userMode = 1'b0;
  logic [2:0]  regNum = '0;
  logic [31:0] regWdata = '0;
  logic        srchHit = 1'b0;
  logic [IW-1:0] srchIdx = '0;

  logic [31:0] rdata [3];
  logic        busyV [3];
  logic [IW-1:0] ramIdxV [3];
  logic        tagWeV [3], dLoV [3], dHiV [3], tidWeV [3], reqV [3], userV [3];
  logic [31:0] ramWdV [3], vpnV [3], zoneV [3];
  logic [7:0]  tidWdV [3], pidV [3];

  logic [31:0] tagMem [ENT];
  logic [63:0] dataMem [ENT];
  logic [7:0]  tidMem [ENT];

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] cap [3];

  tlbMaintRegs #(.ACCESS_LEVEL(3)) i_tlbMaintRegs (
    .clk(clk), .rstN(rstN), .regWr(wrSel[0]), .regRd(rdSel[0]), .regExt(regExt),
    .regNum(regNum), .regWdata(regWdata), .regRdata(rdata[0]), .userMode(userMode),
    .busy(busyV[0]), .ramIdx(ramIdxV[0]), .tagWe(tagWeV[0]), .dataWeLo(dLoV[0]),
    .dataWeHi(dHiV[0]), .ramWdata(ramWdV[0]), .tidWe(tidWeV[0]), .tidWdata(tidWdV[0]),
    .tagRdata(tagMem[ramIdxV[0]]), .dataRdata(dataMem[ramIdxV[0]]), .tidRdata(tidMem[ramIdxV[0]]),
    .srchReq(reqV[0]), .srchVpn(vpnV[0]), .srchUser(userV[0]), .srchHit(srchHit),
    .srchIdx(srchIdx), .curPid(pidV[0]), .zoneProt(zoneV[0]));

  tlbMaintRegs #(.ACCESS_LEVEL(2)) i_lvl2 (
    .clk(clk), .rstN(rstN), .regWr(wrSel[1]), .regRd(rdSel[1]), .regExt(regExt),
    .regNum(regNum), .regWdata(regWdata), .regRdata(rdata[1]), .userMode(userMode),
    .busy(busyV[1]), .ramIdx(ramIdxV[1]), .tagWe(tagWeV[1]), .dataWeLo(dLoV[1]),
    .dataWeHi(dHiV[1]), .ramWdata(ramWdV[1]), .tidWe(tidWeV[1]), .tidWdata(tidWdV[1]),
    .tagRdata(32'hA5A5_0001), .dataRdata(64'h0123_4567_89AB_CDEF), .tidRdata(8'h3C),
    .srchReq(reqV[1]), .srchVpn(vpnV[1]), .srchUser(userV[1]), .srchHit(srchHit),
    .srchIdx(srchIdx), .curPid(pidV[1]), .zoneProt(zoneV[1]));

  tlbMaintRegs #(.ACCESS_LEVEL(1)) i_lvl1 (
    .clk(clk), .rstN(rstN), .regWr(wrSel[2]), .regRd(rdSel[2]), .regExt(regExt),
    .regNum(regNum), .regWdata(regWdata), .regRdata(rdata[2]), .userMode(userMode),
    .busy(busyV[2]), .ramIdx(ramIdxV[2]), .tagWe(tagWeV[2]), .dataWeLo(dLoV[2]),
    .dataWeHi(dHiV[2]), .ramWdata(ramWdV[2]), .tidWe(tidWeV[2]), .tidWdata(tidWdV[2]),
    .tagRdata(32'hA5A5_0001), .dataRdata(64'h0123_4567_89AB_CDEF), .tidRdata(8'h3C),
    .srchReq(reqV[2]), .srchVpn(vpnV[2]), .srchUser(userV[2]), .srchHit(srchHit),
    .srchIdx(srchIdx), .curPid(pidV[2]), .zoneProt(zoneV[2]));

  always @(posedge clk) begin
    if (tagWeV[0]) tagMem[ramIdxV[0]] <= ramWdV[0];
    if (tidWeV[0]) tidMem[ramIdxV[0]] <= tidWdV[0];
    if (dLoV[0])   dataMem[ramIdxV[0]][31:0]  <= ramWdV[0];
    if (dHiV[0])   dataMem[ramIdxV[0]][63:32] <= ramWdV[0];
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [2:0] m, logic [2:0] n, logic x, logic [31:0] d);
    @(negedge clk);
    wrSel = m; regNum = n; regExt = x; regWdata = d;
    @(negedge clk);
    wrSel = '0; regExt = 1'b0;
  endtask

  task automatic doRead(logic [2:0] m, logic [2:0] n, logic x);
    @(negedge clk);
    rdSel = m; regNum = n; regExt = x;
    #1;
    for (int i = 0; i < 3; i++) cap[i] = rdata[i];
    @(negedge clk);
    rdSel = '0; regExt = 1'b0;
  endtask

  task automatic testReset();
    check("R1 busy", busyV[0], 0);
    check("R1 pid out", pidV[0], 0);
    check("R1 zone out", zoneV[0], 0);
    doRead(3'b001, 3'd4, 0); check("R1 index", cap[0], 0);
    doRead(3'b001, 3'd2, 0); check("R1 pid read", cap[0], 0);
  endtask

  task automatic testIndex();
    doWrite(3'b001, 3'd4, 0, 32'hFFFF_FFFF);
    doRead(3'b001, 3'd4, 0);
    check("R2 bit31 read-only", cap[0], 32'h7FFF_FFFF);
    check("R2 ramIdx all ones", ramIdxV[0], 6'h3F);
    doWrite(3'b001, 3'd4, 0, 32'd5);
    check("R2 ramIdx 5", ramIdxV[0], 6'd5);
  endtask

  task automatic testTagData();
    doWrite(3'b001, 3'd2, 0, 32'h1234_5677);
    check("R10 pid written", pidV[0], 8'h77);
    doWrite(3'b001, 3'd1, 0, 32'hC000_0240);
    check("R3 tag stored", tagMem[5], 32'hC000_0240);
    check("R3 tid stamped", tidMem[5], 8'h77);
    doWrite(3'b001, 3'd0, 0, 32'h1111_2222);
    doWrite(3'b001, 3'd0, 1, 32'h3333_4444);
    check("R4 data word", dataMem[5], 64'h3333_4444_1111_2222);
    doRead(3'b001, 3'd0, 0); check("R6 low half", cap[0], 32'h1111_2222);
    doRead(3'b001, 3'd0, 1); check("R6 high half", cap[0], 32'h3333_4444);
  endtask

  task automatic testTagRead();
    doWrite(3'b001, 3'd2, 0, 32'h99);
    check("R10 pid 99", pidV[0], 8'h99);
    doRead(3'b001, 3'd1, 0);
    check("R5 tag read", cap[0], 32'hC000_0240);
    check("R5 pid reload", pidV[0], 8'h77);
    doRead(3'b001, 3'd2, 0);
    check("R5 pid read", cap[0], 32'h77);
  endtask

  task automatic testSearchMiss();
    doWrite(3'b001, 3'd4, 0, 32'h0000_0123);
    srchHit = 1'b0; userMode = 1'b1;
    doWrite(3'b001, 3'd5, 0, 32'hABCD_E7FF);
    check("R7 busy", busyV[0], 1);
    check("R7 request", reqV[0], 1);
    check("R7 vpn", vpnV[0], 32'hABCD_E400);
    check("R7 mode", userV[0], 1);
    wrSel = 3'b001; regNum = 3'd3; regWdata = 32'h55;
    #1; check("R12 no tag write while busy", tagWeV[0], 0);
    @(negedge clk);
    wrSel = '0; userMode = 1'b0;
    check("R7 busy drops", busyV[0], 0);
    check("R12 zone untouched", zoneV[0], 0);
    doRead(3'b001, 3'd4, 0);
    check("R7 miss flag", cap[0], 32'h8000_0123);
    doWrite(3'b001, 3'd4, 0, 32'h0000_0004);
    doRead(3'b001, 3'd4, 0);
    check("R2 flag survives write", cap[0], 32'h8000_0004);
  endtask

  task automatic testSearchHit();
    srchHit = 1'b1; srchIdx = 6'd9;
    doWrite(3'b001, 3'd5, 0, 32'h0000_1000);
    @(negedge clk);
    srchHit = 1'b0;
    doRead(3'b001, 3'd4, 0);
    check("R7 hit index", cap[0], 32'd9);
  endtask

  task automatic testUndefined();
    doRead(3'b001, 3'd5, 0); check("R8 search reads 0", cap[0], 0);
    doWrite(3'b001, 3'd6, 0, 32'hFFFF_FFFF);
    doRead(3'b001, 3'd6, 0); check("R8 reg6 reads 0", cap[0], 0);
    doRead(3'b001, 3'd7, 0); check("R8 reg7 reads 0", cap[0], 0);
    doRead(3'b001, 3'd4, 0); check("R8 index unchanged", cap[0], 32'd9);
    check("R8 zone unchanged", zoneV[0], 0);
    check("R8 pid unchanged", pidV[0], 8'h77);
  endtask

  task automatic testExt();
    doWrite(3'b001, 3'd3, 1, 32'hDEAD_BEEF);
    check("R9 ext zone write ignored", zoneV[0], 0);
    doWrite(3'b001, 3'd1, 1, 32'h1234_0000);
    check("R9 ext tag write ignored", tagMem[9], 0);
    doRead(3'b001, 3'd4, 1); check("R9 ext index read 0", cap[0], 0);
    doWrite(3'b001, 3'd3, 0, 32'h0F0F_F0F0);
    check("R10 zone written", zoneV[0], 32'h0F0F_F0F0);
    doRead(3'b001, 3'd3, 0); check("R10 zone read", cap[0], 32'h0F0F_F0F0);
  endtask

  task automatic testLevels();
    doWrite(3'b110, 3'd2, 0, 32'h42);
    check("R10 level2 pid write", pidV[1], 8'h42);
    check("R10 level1 pid refused", pidV[2], 0);
    doWrite(3'b100, 3'd3, 0, 32'h77);
    check("R10 level1 zone refused", zoneV[2], 0);
    doWrite(3'b100, 3'd5, 0, 32'h4000);
    check("R10 level1 search refused", busyV[2], 0);
    check("R10 level1 no request", reqV[2], 0);
    doRead(3'b110, 3'd1, 0);
    check("R11 level2 tag read 0", cap[1], 0);
    check("R11 level1 tag read", cap[2], 32'hA5A5_0001);
    check("R11 level2 pid kept", pidV[1], 8'h42);
    check("R11 level1 pid reload", pidV[2], 8'h3C);
    doRead(3'b010, 3'd2, 0); check("R11 level2 pid read 0", cap[1], 0);
    doWrite(3'b110, 3'd4, 0, 32'd7);
    doRead(3'b110, 3'd4, 0);
    check("R11 level2 index read", cap[1], 32'd7);
    check("R11 level1 index read", cap[2], 32'd7);
  endtask

  initial begin
    for (int i = 0; i < ENT; i++) begin
      tagMem[i] = '0; dataMem[i] = '0; tidMem[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIndex();
    testTagData();
    testTagRead();
    testSearchMiss();
    testSearchHit();
    testUndefined();
    testExt();
    testLevels();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule